// File: doc/BRIEF.md
# Pointer-Indexed I2C Register Slave

This block is an I2C target that exposes a small register file through two logical ports. Both ports share one 7-bit bus address, except for the address LSB. When that bit is 0, the transfer reaches an index register. This is the pointer, and it names the register to be accessed. When the bit is 1, the transfer reads or writes the register that the pointer currently names. The upper six address bits come from a pin strap, `dev_addr`, which is captured while reset is asserted and is frozen after that.

The register file holds eight registers:
- Indices 0 to 3 are read/write. They are intended as identity low, identity high, control and configuration. All four are exported as one flat vector.
- Indices 4 to 7 are read-only event counters: error A, error B, bunch and event. Each one counts single-cycle strobes on `ev_inc`. Writing any byte to a counter's index clears that counter.

SCL and SDA are sampled with the system clock through synchronisers. SDA is open-drain, so the block only decides when to pull the line low.

Top module: `i2c_ptr_slave`

## Requirements
- R1: While `rst` is high, and directly after it falls, `sda_oe` is 0, every read/write register is 0, every counter is 0 and the pointer is 0.
- R2: An address byte is acknowledged (SDA pulled low during the ninth SCL pulse) only when its bits 7:2 equal the captured device address. Any other address gets no acknowledge, and SDA is not driven until the next START.
- R3: `dev_addr` is captured while `rst` is high. Changing it after reset has no effect on which address is answered.
- R4: A write to the address with LSB 0 stores the data byte in the pointer. A read from that address returns the pointer.
- R5: A write to the address with LSB 1 stores the byte in read/write register p when the pointer p is between 0 and 3. Register p appears on `rw_regs[8p+7:8p]`.
- R6: A read with LSB 1 returns the register the pointer names. For pointer values of 8 and above, a read returns 0 and a write changes nothing.
- R7: Counter k (index 4+k) increments by one for each cycle in which `ev_inc[k]` is high, and wraps from 255 to 0.
- R8: Writing any byte to a counter's index clears only that counter. The clear takes priority over a simultaneous increment.
- R9: The pointer never auto-increments. It changes only on a pointer write and keeps its value across transactions. Several data bytes in one write transaction all land in the same register.
- R10: Every data byte written to an addressed slave is acknowledged. On a read, a master ACK makes the slave send another byte. A master NACK leaves SDA released until the next START.
- R11: Read data is sent MSB first. `sda_oe` never goes high while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling SCL |
| rst | input | 1 | Synchronous active-high reset; device address captured while high |
| dev_addr | input | 6 | Strapped upper six bits of the bus address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| ev_inc | input | 4 | Increment strobes for the four counters |
| rw_regs | output | 32 | Read/write registers 0..3, register p in bits 8p+7:8p |

## Verification
Some properties are checked by assertions on every cycle:
- SDA is never newly pulled low while the synchronised SCL is high.
- The pointer moves only on a pointer write.
- The captured device address stays fixed.
- Each counter either steps by one or returns to zero, and a counter write is followed by a zero count.

Other behaviour is shown only by the bench's bus scenarios:
- Address matching, and ignoring the strap after reset.
- The data values returned through the pointer for each register class.
- Wrap after 256 events.
- The effect of master ACK or NACK on read continuation.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & ~sda_s & sda_d;
  assign stop_det  = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/i2c_ptr_engine.sv
module i2c_ptr_engine
  import i2c_ptr_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [AW-1:0] dev_id,
  input  logic [DW-1:0] ptr_q,
  input  logic [DW-1:0] reg_q,
  output logic          sda_oe,
  output logic          wr_en,
  output logic          wr_sel,
  output logic [DW-1:0] wdata
);
  localparam int ALEN = AW + 2;
  localparam int SW   = (DW > ALEN) ? DW : ALEN;
  localparam int CW   = $clog2(SW + 1);

  bus_st_e       st;
  logic [SW-1:0] shreg;
  logic [DW-1:0] tx;
  logic [CW-1:0] cnt;
  logic          sel, rnw, nack;
  logic [DW-1:0] rd_byte;

  assign rd_byte = sel ? reg_q : ptr_q;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      tx     <= '0;
      sel    <= 1'b0;
      rnw    <= 1'b0;
      nack   <= 1'b0;
      wr_sel <= 1'b0;
      wdata  <= '0;
    end else if (start_det) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR: begin
          if (scl_rise) begin
            shreg <= {shreg[SW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == CW'(ALEN)) begin
            if (shreg[ALEN-1:2] == dev_id) begin
              st     <= S_AACK;
              sda_oe <= 1'b1;
              sel    <= shreg[1];
              rnw    <= shreg[0];
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          cnt <= '0;
          if (rnw) begin
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[DW-1];
            st     <= S_RD;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_WR;
          end
        end
        S_WR: begin
          if (scl_rise) begin
            shreg <= {shreg[SW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == CW'(DW)) begin
            sda_oe <= 1'b1;
            st     <= S_WACK;
            wr_en  <= 1'b1;
            wr_sel <= sel;
            wdata  <= shreg[DW-1:0];
          end
        end
        S_WACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          st     <= S_WR;
        end
        S_RD: if (scl_fall) begin
          if (cnt == CW'(DW - 1)) begin
            sda_oe <= 1'b0;
            st     <= S_RACK;
          end else begin
            tx     <= {tx[DW-2:0], 1'b0};
            sda_oe <= ~tx[DW-2];
            cnt    <= cnt + 1'b1;
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              st <= S_IDLE;
            end else begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[DW-1];
              cnt    <= '0;
              st     <= S_RD;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_ptr_regs.sv
module i2c_ptr_regs #(
  parameter int DW   = 8,
  parameter int NRW  = 4,
  parameter int NCNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DW-1:0]     wdata,
  input  logic [NCNT-1:0]   ev_inc,
  output logic [DW-1:0]     ptr_q,
  output logic [DW-1:0]     reg_q,
  output logic [NRW*DW-1:0] rw_flat,
  output logic [NCNT*DW-1:0] cnt_flat
);
  logic [DW-1:0] rw_r  [NRW];
  logic [DW-1:0] cnt_r [NCNT];
  logic          data_wr;

  assign data_wr = wr_en & wr_sel;

  always_ff @(posedge clk) begin
    if (rst)                  ptr_q <= '0;
    else if (wr_en && !wr_sel) ptr_q <= wdata;
  end

  for (genvar g = 0; g < NRW; g++) begin : g_rw
    always_ff @(posedge clk) begin
      if (rst)                                rw_r[g] <= '0;
      else if (data_wr && ptr_q == DW'(g))    rw_r[g] <= wdata;
    end
    assign rw_flat[g*DW +: DW] = rw_r[g];
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                                   cnt_r[g] <= '0;
      else if (data_wr && ptr_q == DW'(NRW + g)) cnt_r[g] <= '0;
      else if (ev_inc[g])                        cnt_r[g] <= cnt_r[g] + 1'b1;
    end
    assign cnt_flat[g*DW +: DW] = cnt_r[g];
  end

  always_comb begin
    reg_q = '0;
    for (int i = 0; i < NRW; i++)
      if (ptr_q == DW'(i)) reg_q = rw_r[i];
    for (int j = 0; j < NCNT; j++)
      if (ptr_q == DW'(NRW + j)) reg_q = cnt_r[j];
  end
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
  parameter int DW    = 8,
  parameter int AW    = 6,
  parameter int NRW   = 4,
  parameter int NCNT  = 4,
  parameter int SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     dev_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [NCNT-1:0]   ev_inc,
  output logic [NRW*DW-1:0] rw_regs
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0]     dev_id;
  logic [DW-1:0]     ptr_q, reg_q, wdata;
  logic              wr_en, wr_sel;
  logic [NCNT*DW-1:0] cnt_flat;

  always_ff @(posedge clk) begin
    if (rst) dev_id <= dev_addr;
  end

  i2c_line_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ptr_engine #(.DW(DW), .AW(AW)) u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .dev_id(dev_id), .ptr_q(ptr_q), .reg_q(reg_q), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_sel(wr_sel), .wdata(wdata)
  );

  i2c_ptr_regs #(.DW(DW), .NRW(NRW), .NCNT(NCNT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wdata(wdata),
    .ev_inc(ev_inc), .ptr_q(ptr_q), .reg_q(reg_q), .rw_flat(rw_regs),
    .cnt_flat(cnt_flat)
  );
endmodule

// File: rtl/i2c_ptr_slave_chk.sv
module i2c_ptr_slave_chk #(
  parameter int DW   = 8,
  parameter int AW   = 6,
  parameter int NRW  = 4,
  parameter int NCNT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_s,
  input logic               sda_oe,
  input logic               wr_en,
  input logic               wr_sel,
  input logic [DW-1:0]      ptr,
  input logic [NCNT*DW-1:0] cnt_flat,
  input logic [AW-1:0]      dev_id
);
  // R1: bus released and pointer cleared on the first cycle out of reset
  a_r1_reset_exit: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && ptr == '0));

  // R11: SDA is only newly pulled low while SCL is low
  a_r11_no_pull_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> !$rose(sda_oe));

  // R9: pointer moves only on a pointer-port write
  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !wr_sel) |=> $stable(ptr));

  // R3: captured device address stays fixed after reset
  a_r3_devid_frozen: assert property (@(posedge clk) disable iff (rst)
    $stable(dev_id));

  for (genvar g = 0; g < NCNT; g++) begin : g_chk
    // R8: a data write at a counter index leaves it at zero
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel && ptr == DW'(NRW + g)) |=> cnt_flat[g*DW +: DW] == '0);
    // R7: a counter steps by one or returns to zero
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
      (cnt_flat[g*DW +: DW] != $past(cnt_flat[g*DW +: DW])) |->
      (cnt_flat[g*DW +: DW] == $past(cnt_flat[g*DW +: DW]) + DW'(1) ||
       cnt_flat[g*DW +: DW] == '0));
  end
endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk #(.DW(DW), .AW(AW), .NRW(NRW), .NCNT(NCNT)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .wr_en(wr_en),
  .wr_sel(wr_sel), .ptr(ptr_q), .cnt_flat(cnt_flat), .dev_id(dev_id)
);

// File: tb/sim_i2c_ptr_slave.sv
module sim_i2c_ptr_slave;
  localparam int DW = 8, AW = 6, NRW = 4, NCNT = 4, HP = 10;
  localparam logic [AW-1:0] DEV = 6'h2B;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [AW-1:0] dev_addr = DEV;
  logic [NCNT-1:0] ev_inc = '0;
  logic sda_oe;
  logic [NRW*DW-1:0] rw_regs;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2c_ptr_slave #(.DW(DW), .AW(AW), .NRW(NRW), .NCNT(NCNT)) u0 (
    .clk(clk), .rst(rst), .dev_addr(dev_addr), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .ev_inc(ev_inc), .rw_regs(rw_regs)
  );

  int errors = 0, checks = 0, viol = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];
  event       got_ev;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic sb_expect(string tag, logic [7:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic sb_observe(logic [7:0] v);
    act_q.push_back(v);
    -> got_ev;
  endtask

  task automatic sb_drain();
    while (act_q.size() > 0) begin
      logic [7:0] a;
      a = act_q.pop_front();
      if (exp_q.size() == 0) check("scoreboard underrun", {24'h0, a}, 32'hFFFF_FFFF);
      else check(tag_q.pop_front(), {24'h0, a}, {24'h0, exp_q.pop_front()});
    end
  endtask

  initial forever begin
    @(got_ev);
    sb_drain();
  end

  // R11 bench-side: SDA must not start being pulled while SCL is high
  logic prev_oe = 1'b0;
  always @(posedge clk) begin
    if (!rst && scl_m && sda_oe && !prev_oe) viol++;
    prev_oe <= sda_oe;
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(HP);
    sda_m = 1'b0; wait_clk(HP);
    scl_m = 1'b0; wait_clk(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(HP);
    scl_m = 1'b1; wait_clk(HP);
    sda_m = 1'b1; wait_clk(HP);
  endtask

  task automatic send_bit(logic b);
    wait_clk(2);
    sda_m = b; wait_clk(HP - 2);
    scl_m = 1'b1; wait_clk(HP);
    scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    wait_clk(2);
    sda_m = 1'b1; wait_clk(HP - 2);
    scl_m = 1'b1; wait_clk(HP / 2);
    b = sda_line; wait_clk(HP / 2);
    scl_m = 1'b0;
  endtask

  task automatic wr_byte(logic [7:0] b, bit exp_ack, string tag);
    logic bt;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(bt);
    sb_expect(tag, exp_ack ? 8'h00 : 8'h01);
    sb_observe({7'h0, bt});
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic last);
    logic bt;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(bt);
      v[i] = bt;
    end
    send_bit(last);
  endtask

  task automatic ptr_set(logic [7:0] p, string tag);
    bus_start();
    wr_byte({DEV, 2'b00}, 1'b1, {tag, " addr ack"});
    wr_byte(p, 1'b1, {tag, " R10 ptr byte ack"});
    bus_stop();
  endtask

  task automatic data_wr(logic [7:0] v, string tag);
    bus_start();
    wr_byte({DEV, 2'b10}, 1'b1, {tag, " addr ack"});
    wr_byte(v, 1'b1, {tag, " R10 data byte ack"});
    bus_stop();
  endtask

  task automatic port_rd(logic lsb, logic [7:0] e, string tag);
    logic [7:0] v;
    bus_start();
    wr_byte({DEV, lsb, 1'b1}, 1'b1, {tag, " addr ack"});
    sb_expect(tag, e);
    rd_byte(v, 1'b1);
    sb_observe(v);
    bus_stop();
  endtask

  task automatic pulse(int idx, int n);
    repeat (n) begin
      @(negedge clk); ev_inc[idx] = 1'b1;
      @(negedge clk); ev_inc[idx] = 1'b0;
    end
  endtask

  initial begin
    logic [7:0] v;
    wait_clk(5);
    check("R1 sda_oe in reset", {31'h0, sda_oe}, 32'h0);
    rst = 1'b0;
    wait_clk(2);
    check("R1 sda_oe after reset", {31'h0, sda_oe}, 32'h0);
    check("R1 rw regs after reset", rw_regs, 32'h0);
    dev_addr = 6'h15;                       // R3: strap moves after reset
    port_rd(1'b0, 8'h00, "R1 pointer reset value");

    ptr_set(8'h02, "R4");
    port_rd(1'b0, 8'h02, "R4 pointer readback");
    data_wr(8'hA5, "R5");
    check("R5 reg2 on rw_regs", {24'h0, rw_regs[23:16]}, 32'hA5);
    port_rd(1'b1, 8'hA5, "R11 msb-first data read");

    ptr_set(8'h00, "R5");
    data_wr(8'h3C, "R5");
    check("R5 reg0 on rw_regs", {24'h0, rw_regs[7:0]}, 32'h3C);

    ptr_set(8'h01, "R9");
    bus_start();
    wr_byte({DEV, 2'b10}, 1'b1, "R9 addr ack");
    wr_byte(8'h11, 1'b1, "R10 first data ack");
    wr_byte(8'h22, 1'b1, "R10 second data ack");
    bus_stop();
    check("R9 burst lands in reg1", {24'h0, rw_regs[15:8]}, 32'h22);
    check("R9 reg2 untouched by burst", {24'h0, rw_regs[23:16]}, 32'hA5);
    port_rd(1'b1, 8'h22, "R9 read one");
    port_rd(1'b1, 8'h22, "R9 read two same reg");

    bus_start();
    wr_byte({DEV, 2'b11}, 1'b1, "R10 addr ack");
    sb_expect("R10 byte after master ACK", 8'h22);
    rd_byte(v, 1'b0);
    sb_observe(v);
    sb_expect("R10 byte before master NACK", 8'h22);
    rd_byte(v, 1'b1);
    sb_observe(v);
    wait_clk(6);
    check("R10 SDA released after NACK", {31'h0, sda_oe}, 32'h0);
    bus_stop();

    bus_start();
    wr_byte({6'h15, 2'b11}, 1'b0, "R3 new strap value ignored");
    bus_stop();
    bus_start();
    wr_byte({DEV ^ 6'h20, 2'b01}, 1'b0, "R2 foreign address no ack");
    bus_stop();
    port_rd(1'b0, 8'h01, "R2 pointer unchanged by foreign traffic");

    pulse(0, 3);
    pulse(2, 5);
    ptr_set(8'h04, "R7");
    port_rd(1'b1, 8'h03, "R7 error A count");
    ptr_set(8'h06, "R7");
    port_rd(1'b1, 8'h05, "R7 bunch count");
    pulse(3, 257);
    ptr_set(8'h07, "R7");
    port_rd(1'b1, 8'h01, "R7 event count wraps");

    ptr_set(8'h04, "R8");
    data_wr(8'h77, "R8");
    port_rd(1'b1, 8'h00, "R8 counter cleared by write");
    ptr_set(8'h06, "R8");
    port_rd(1'b1, 8'h05, "R8 other counter kept");

    ptr_set(8'h09, "R6");
    data_wr(8'h5A, "R6");
    port_rd(1'b1, 8'h00, "R6 unmapped index reads zero");
    check("R6 unmapped write ignored", rw_regs, 32'h00A5_223C);

    check("R11 no SDA pull while SCL high", viol, 0);
    wait_clk(4);
    sb_drain();
    check("scoreboard leftover expectations", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule